// File: doc/BRIEF.md
# External Bus Strobe Generator

This block sequences the machine cycle of an 8-bit controller core that takes its code from external memory and can also move data to and from external data memory. It counts oscillator periods into a machine cycle of six states with two phases each. From that count it produces the address-latch strobe (`ale`, active high) and the code-read strobe (`psen_n`, active low). It also reports the current state number and phase, which the rest of the core uses to time its own actions.

The surrounding core tells the block what kind of machine cycle it is running. One flag marks an external data-memory transfer, and another marks a code-table read. A third control bit turns off free-running ALE. With that bit set, ALE appears only where an external data transfer or a code-table read needs it, which reduces switching noise on the board. The flags are taken in only at the edge that starts a new machine cycle. Each cycle's strobe pattern is therefore decided as a whole.

Top module: `ext_bus_strobe`

## Requirements
- R1: While `rst` is high (sampled at a rising clock edge), the next outputs are `ale`=0, `psen_n`=1, `mc_state`=1 and `mc_phase`=0. The machine cycle that begins when reset is released is an ordinary fetch cycle, whatever the flag inputs hold.
- R2: A machine cycle is 12 clocks long. Slot k (0..11) has `mc_state` = k/2+1, binary 1..6, and `mc_phase` = k mod 2 (0 is the first phase). The slot advances by one on every clock and wraps from 11 to 0.
- R3: In an ordinary cycle with ALE enabled, `ale` is high in slots 1–2 and 7–8 and low elsewhere. This gives two pulses per machine cycle, one per six clocks.
- R4: In a fetch cycle, `psen_n` is low in slots 3–5 and 9–11 and high elsewhere. `ale` and a low `psen_n` never overlap.
- R5: In an external data cycle (`xdata_cyc`=1 at the cycle start), the slot 1–2 ALE pulse is kept to latch the data address, the slot 7–8 ALE pulse is dropped, and `psen_n` stays high for the whole cycle.
- R6: With `ale_off`=1 at the cycle start, an ordinary fetch cycle produces no ALE pulse. Its `psen_n` pattern is unchanged.
- R7: With `ale_off`=1, a code-table read cycle (`table_rd`=1) still produces both ALE pulses, and a data cycle still produces its slot 1–2 pulse.
- R8: `xdata_cyc`, `table_rd` and `ale_off` are sampled only at the edge that moves the slot from 11 to 0. Changes at any other time have no effect on the current cycle. If both `xdata_cyc` and `table_rd` are high, the cycle is a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| xdata_cyc | input | 1 | Next machine cycle is an external data transfer |
| table_rd | input | 1 | Next machine cycle is a code-table read |
| ale_off | input | 1 | Suppress free-running ALE |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| mc_state | output | 3 | Current state of the machine cycle, 1..6 |
| mc_phase | output | 1 | Current phase within the state |

## Verification
The bench keeps random noise on the three flag inputs through every clock. Only the values present at the slot 11 to 0 edge should matter. A design that samples them at any other time would change its strobes part-way through a cycle. Directed cycles cover every flag combination, including data-and-table together. Here a design that favours the table read would emit a second ALE pulse and fetch pulses during a data transfer. A reset in the middle of a cycle checks that the slot count restarts at state 1 with the strobes idle, instead of finishing the interrupted cycle.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

  // Flags that shape the strobe pattern of one machine cycle
  typedef struct packed {
    logic xd;     // external data transfer
    logic tbl;    // code-table read
    logic quiet;  // free-running ALE suppressed
  } cyc_flags_t;

endpackage

// File: rtl/bus_slot_timer.sv
module bus_slot_timer #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SLOTS = STATES * PHASES,
  localparam int CW    = $clog2(SLOTS),
  localparam int SW    = $clog2(STATES + 1),
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] slot_nxt,
  output logic          start_nxt,
  output logic [SW-1:0] mc_state,
  output logic [PW-1:0] mc_phase
);

  logic [CW-1:0] slot_q;

  always_comb begin
    if (rst || slot_q == CW'(SLOTS - 1))
      slot_nxt = '0;
    else
      slot_nxt = slot_q + 1'b1;
    start_nxt = (slot_nxt == '0);
  end

  always_ff @(posedge clk) begin
    slot_q <= slot_nxt;
  end

  assign mc_state = SW'(slot_q / CW'(PHASES)) + 1'b1;
  assign mc_phase = PW'(slot_q % CW'(PHASES));

endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
  import ext_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_nxt,
  input  cyc_flags_t flags_in,
  output cyc_flags_t flags_nxt,
  output logic       cur_xd
);

  cyc_flags_t flags_q;

  // Flags are taken in only when a new machine cycle begins
  always_comb begin
    if (rst)
      flags_nxt = '0;
    else if (start_nxt) begin
      flags_nxt = flags_in;
      if (flags_in.xd)
        flags_nxt.tbl = 1'b0;   // a data transfer outranks a table read
    end else
      flags_nxt = flags_q;
  end

  always_ff @(posedge clk) begin
    flags_q <= flags_nxt;
  end

  assign cur_xd = flags_q.xd;

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import ext_bus_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SLOTS = STATES * PHASES,
  localparam int HALF  = SLOTS / 2,
  localparam int CW    = $clog2(SLOTS),
  localparam int ALE_A = PHASES - 1,        // first ALE slot in each half
  localparam int ALE_B = ALE_A + PHASES,    // first slot after ALE
  localparam int RD_A  = ALE_B              // code read follows ALE fall
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] slot_nxt,
  input  cyc_flags_t    flags_nxt,
  output logic          ale,
  output logic          psen_n
);

  logic          second;
  logic [CW-1:0] pos;
  logic          ale_win, rd_win;
  logic          ale_d, psen_d_n;

  always_comb begin
    second = (slot_nxt >= CW'(HALF));
    pos    = second ? slot_nxt - CW'(HALF) : slot_nxt;
    ale_win = (pos >= CW'(ALE_A)) && (pos < CW'(ALE_B));
    rd_win  = (pos >= CW'(RD_A))  && (pos < CW'(HALF));
    if (!ale_win)
      ale_d = 1'b0;
    else if (second)
      ale_d = !flags_nxt.xd && (!flags_nxt.quiet || flags_nxt.tbl);
    else
      ale_d = flags_nxt.xd || !flags_nxt.quiet || flags_nxt.tbl;
    psen_d_n = !(rd_win && !flags_nxt.xd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_d;
      psen_n <= psen_d_n;
    end
  end

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import ext_bus_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SLOTS = STATES * PHASES,
  localparam int CW    = $clog2(SLOTS),
  localparam int SW    = $clog2(STATES + 1),
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xdata_cyc,
  input  logic          table_rd,
  input  logic          ale_off,
  output logic          ale,
  output logic          psen_n,
  output logic [SW-1:0] mc_state,
  output logic [PW-1:0] mc_phase
);

  logic [CW-1:0] slot_nxt;
  logic          start_nxt;
  cyc_flags_t    flags_in, flags_nxt;
  logic          cur_xd;

  assign flags_in = '{xd: xdata_cyc, tbl: table_rd, quiet: ale_off};

  bus_slot_timer #(.STATES(STATES), .PHASES(PHASES)) u_timer (
    .clk(clk), .rst(rst), .slot_nxt(slot_nxt), .start_nxt(start_nxt),
    .mc_state(mc_state), .mc_phase(mc_phase)
  );

  bus_cycle_ctl u_ctl (
    .clk(clk), .rst(rst), .start_nxt(start_nxt), .flags_in(flags_in),
    .flags_nxt(flags_nxt), .cur_xd(cur_xd)
  );

  bus_strobe_dec #(.STATES(STATES), .PHASES(PHASES)) u_dec (
    .clk(clk), .rst(rst), .slot_nxt(slot_nxt), .flags_nxt(flags_nxt),
    .ale(ale), .psen_n(psen_n)
  );

endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk #(
  parameter int STATES = 6,
  parameter int SW = 3,
  parameter int PW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          psen_n,
  input logic [SW-1:0] mc_state,
  input logic [PW-1:0] mc_phase,
  input logic          cur_xd
);

  // R4
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  // R2
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_state >= SW'(1)) && (mc_state <= SW'(STATES)));

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mc_phase != $past(mc_phase)));

  // R2
  state_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_phase == PW'(1) && mc_state != SW'(STATES)) |=>
      (mc_state == $past(mc_state) + SW'(1)));

  // R3
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);

  // R5
  no_fetch_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    cur_xd |-> psen_n);

endmodule

bind ext_bus_strobe ext_bus_strobe_chk #(.STATES(STATES), .SW(SW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n),
  .mc_state(mc_state), .mc_phase(mc_phase), .cur_xd(cur_xd)
);

// File: tb/ext_bus_strobe_test.sv
module ext_bus_strobe_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xdata_cyc = 1'b0, table_rd = 1'b0, ale_off = 1'b0;
  logic       ale, psen_n;
  logic [2:0] mc_state;
  logic [0:0] mc_phase;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model of the cycle
  int exp_slot = 0;
  bit c_xd = 0, c_tb = 0, c_off = 0;
  bit p_xd = 0, p_tb = 0, p_off = 0;

  always #2.5 clk = ~clk;

  ext_bus_strobe uut (
    .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .table_rd(table_rd),
    .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
    .mc_state(mc_state), .mc_phase(mc_phase)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (slot %0d)", tag, act, exp, exp_slot);
    end
  endtask

  function automatic bit exp_ale(int s, bit xd, bit tb, bit off);
    if (s == 1 || s == 2) return xd || !off || tb;
    if (s == 7 || s == 8) return !xd && (!off || tb);
    return 0;
  endfunction

  function automatic bit exp_psen_n(int s, bit xd);
    if ((s >= 3 && s <= 5) || (s >= 9 && s <= 11)) return xd;
    return 1;
  endfunction

  // check outputs at the falling edge, then drive new inputs
  task automatic check_now(bit in_reset);
    string ta, tp;
    bit ex_xd = c_xd, ex_tb = c_tb && !c_xd;
    if (in_reset) begin
      chk("R1 ale", ale, 0);
      chk("R1 psen_n", psen_n, 1);
      chk("R1 state", mc_state, 1);
      chk("R1 phase", mc_phase, 0);
      return;
    end
    if (ex_xd) ta = "R5"; else if (c_off && ex_tb) ta = "R7";
    else if (c_off) ta = "R6"; else ta = "R3";
    tp = ex_xd ? "R5" : "R4";
    if (xdata_cyc != c_xd || table_rd != c_tb || ale_off != c_off) begin
      ta = {ta, " R8"};
      tp = {tp, " R8"};
    end
    chk({ta, " ale"}, ale, exp_ale(exp_slot, ex_xd, ex_tb, c_off));
    chk({tp, " psen_n"}, psen_n, exp_psen_n(exp_slot, ex_xd));
    chk("R2 state", mc_state, exp_slot / 2 + 1);
    chk("R2 phase", mc_phase, exp_slot % 2);
  endtask

  // advance the model across one rising edge
  task automatic step(bit rst_at_edge);
    @(posedge clk);
    if (rst_at_edge) begin
      exp_slot = 0; c_xd = 0; c_tb = 0; c_off = 0;
    end else begin
      exp_slot = (exp_slot + 1) % 12;
      if (exp_slot == 0) begin
        c_xd = p_xd; c_tb = p_tb; c_off = p_off;
      end
    end
    @(negedge clk);
  endtask

  // one machine cycle with the given mode; noise on the inputs elsewhere
  task automatic run_cycle(bit xd, bit tb, bit off);
    for (int k = 0; k < 12; k++) begin
      check_now(0);
      if (exp_slot == 11) begin
        xdata_cyc = xd; table_rd = tb; ale_off = off;
        p_xd = xd; p_tb = tb; p_off = off;
      end else begin
        xdata_cyc = 1'($urandom); table_rd = 1'($urandom); ale_off = 1'($urandom);
      end
      step(0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    xdata_cyc = 1; table_rd = 1; ale_off = 1;   // R1: ignored across reset
    repeat (3) @(negedge clk);
    check_now(1);
    rst = 0;
    // first cycle after reset: ordinary fetch
    p_xd = 0; p_tb = 0; p_off = 0;
    run_cycle(0, 0, 0);
    // directed corners: every flag combination
    for (int m = 0; m < 8; m++) begin
      run_cycle(m[0], m[1], m[2]);
      run_cycle(m[0], m[1], m[2]);
    end
    // mid-cycle reset (R1)
    for (int k = 0; k < 5; k++) begin check_now(0); step(0); end
    rst = 1;
    step(1);
    check_now(1);
    step(1);
    check_now(1);
    rst = 0;
    p_xd = 0; p_tb = 0; p_off = 0;
    run_cycle(1, 1, 0);
    // random cycles
    for (int m = 0; m < 500; m++)
      run_cycle(($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule